// File: doc/BRIEF.md
# Shared Prescaler Periodic Interrupt Timer

This block holds a single free-running prescaler counter that runs on a slow real-time clock and serves two consumers that are configured separately. The first consumer is a tick generator for a real-time counter. It produces a one-cycle count-enable pulse at a power-of-two division ratio set by its own select field. The second consumer is a periodic interrupt timer. It drives a square wave by tapping one bit of the shared counter, and it keeps a sticky interrupt flag that is set on each rising edge of that wave.

The counter runs while at least one of the two enables is high. When both enables are low it is forced to zero. Because of this, the delay to the first timer interrupt depends on the tick generator. If the tick generator is off, enabling the timer restarts the counter from zero and the first edge comes exactly half a period later. If the tick generator is already on, the counter keeps its phase, and the first edge can come at once or up to a full period later.

Top module: `shared_prescaler_timer`

## Requirements
- R1: While both `rtcEn` and `pitEn` are low, the counter is held at zero. A later enable therefore starts counting from zero.
- R2: While either enable is high, the counter advances by one on every clock. It is PRE_W (15) bits wide and wraps from all ones to zero.
- R3: When the counter was stopped and `pitEn` is raised with period select s, `pitWave` first goes high after exactly 2^s clock edges.
- R4: For a period select s in 1..14, `pitWave` equals counter bit s. The wave therefore has a period of 2^(s+1) clocks (s=1 gives 4, s=3 gives 16, s=14 gives 32768).
- R5: When `pitEn` is low, or the period select is 0 (off) or 15 (reserved, treated as off), `pitWave` is held at 0 and `pitFlag` is never set.
- R6: `pitFlag` goes high on the clock edge after `pitWave` goes from 0 to 1.
- R7: `pitFlag` stays high until `flagClr` is high at a clock edge. If a new rising edge of the wave and a clear arrive at the same edge, the flag stays set.
- R8: While `rtcEn` is high, `rtcTick` is high for one cycle each time the low d counter bits are all ones, where d is the division select. This gives one tick per 2^d clocks. d=0 ticks every clock, and d=15 ticks once per counter wrap.
- R9: When `pitEn` is raised while `rtcEn` is already high, the counter is not restarted. `pitWave` at once shows the current value of the tapped bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time clock |
| rstN | input | 1 | Active-low synchronous reset |
| rtcEn | input | 1 | Enables the tick generator |
| pitEn | input | 1 | Enables the periodic interrupt timer |
| divSel | input | 4 | Tick division select d, ratio 2^d |
| perSel | input | 4 | Timer period select s, period 2^(s+1) |
| flagClr | input | 1 | Clears the sticky interrupt flag |
| rtcTick | output | 1 | One-cycle count-enable pulse |
| pitWave | output | 1 | Timer square-wave output |
| pitFlag | output | 1 | Sticky timer interrupt flag |

## Verification
The bench measures the latency of the first timer edge from a stopped counter. A design that failed to restart the counter, or that started it one edge late, would shift that edge away from edge 2^s. It then enables the timer while the tick generator is already running and expects the tapped bit to appear at once. A design that cleared the counter on every enable would show a low wave there instead. It also covers the case where a set and a clear of the flag arrive together, where a design that gave the clear priority would lose an interrupt. Finally it checks the full 15-bit wrap at d=15 and s=14, where a narrow counter or a badly formed mask would move or drop the tick.

// File: rtl/shared_prescaler_pkg.sv
package shared_prescaler_pkg;
  parameter int unsigned PRE_W = 15;
  parameter int unsigned SEL_W = 4;

  typedef struct packed {
    logic             cntRun;
    logic             rtcOn;
    logic             pitOn;
    logic             flagClr;
    logic [PRE_W-1:0] divMask;
    logic [PRE_W-1:0] tapOneHot;
  } ctlStrobes_t;
endpackage

// File: rtl/spt_control.sv
module spt_control
  import shared_prescaler_pkg::*;
#(
  parameter int unsigned CNT_W = PRE_W,
  parameter int unsigned SW    = SEL_W
) (
  input  logic          rtcEn,
  input  logic          pitEn,
  input  logic [SW-1:0] divSel,
  input  logic [SW-1:0] perSel,
  input  logic          flagClr,
  output ctlStrobes_t   ctl
);
  localparam int unsigned PER_MAX = CNT_W - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic perValid;

  always_comb begin
    perValid = (perSel != '0) && (int'(perSel) <= PER_MAX);
    ctl.cntRun  = rtcEn | pitEn;
    ctl.rtcOn   = rtcEn;
    ctl.pitOn   = pitEn & perValid;
    ctl.flagClr = flagClr;
    ctl.divMask = (ONE << divSel) - ONE;
    ctl.tapOneHot = '0;
    for (int b = 1; b <= int'(PER_MAX); b++) begin
      if (ctl.pitOn && int'(perSel) == b) ctl.tapOneHot[b] = 1'b1;
    end
  end
endmodule

// File: rtl/spt_datapath.sv
module spt_datapath
  import shared_prescaler_pkg::*;
#(
  parameter int unsigned CNT_W = PRE_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  output logic        rtcTick,
  output logic        pitWave,
  output logic        pitFlag
);
  logic [CNT_W-1:0] cnt;
  logic             waveQ;
  logic             waveRise;

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (!ctl.cntRun)  cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    rtcTick  = ctl.rtcOn && ((cnt & ctl.divMask) == ctl.divMask);
    pitWave  = ctl.pitOn && ((cnt & ctl.tapOneHot) != '0);
    waveRise = pitWave && !waveQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waveQ   <= 1'b0;
      pitFlag <= 1'b0;
    end else begin
      waveQ <= pitWave;
      if (waveRise)         pitFlag <= 1'b1;
      else if (ctl.flagClr) pitFlag <= 1'b0;
    end
  end

  p_hold_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.cntRun |=> (cnt == '0));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntRun |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pitWave && !waveQ) |=> pitFlag);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pitFlag && !ctl.flagClr) |=> pitFlag);
endmodule

// File: rtl/shared_prescaler_timer.sv
module shared_prescaler_timer
  import shared_prescaler_pkg::*;
#(
  parameter int unsigned CNT_W = PRE_W,
  parameter int unsigned SW    = SEL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rtcEn,
  input  logic          pitEn,
  input  logic [SW-1:0] divSel,
  input  logic [SW-1:0] perSel,
  input  logic          flagClr,
  output logic          rtcTick,
  output logic          pitWave,
  output logic          pitFlag
);
  ctlStrobes_t ctl;

  spt_control #(.CNT_W(CNT_W), .SW(SW)) u_ctrl (
    .rtcEn(rtcEn), .pitEn(pitEn), .divSel(divSel), .perSel(perSel),
    .flagClr(flagClr), .ctl(ctl)
  );

  spt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rtcTick(rtcTick), .pitWave(pitWave), .pitFlag(pitFlag)
  );

  p_pit_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !pitEn |-> !pitWave);
  p_tick_every_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rtcEn && divSel == '0) |-> rtcTick);
  p_no_tick_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rtcEn |-> !rtcTick);
endmodule

// File: tb/shared_prescaler_timer_bench.sv
`timescale 1ns/1ps
module shared_prescaler_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rtcEn = 1'b0, pitEn = 1'b0, flagClr = 1'b0;
  logic [3:0] divSel = '0, perSel = '0;
  logic rtcTick, pitWave, pitFlag;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shared_prescaler_timer u_shared_prescaler_timer (
    .clk(clk), .rstN(rstN), .rtcEn(rtcEn), .pitEn(pitEn),
    .divSel(divSel), .perSel(perSel), .flagClr(flagClr),
    .rtcTick(rtcTick), .pitWave(pitWave), .pitFlag(pitFlag)
  );

  typedef struct packed {
    logic        rtc;
    logic        pit;
    logic [3:0]  d;
    logic [3:0]  s;
    logic [15:0] ticks;
    logic [15:0] rises;
  } vec_t;

  localparam int NV = 8;
  localparam int RUN = 64;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 4'd0, 4'd3, 16'd64, 16'd0},
    '{1'b1, 1'b0, 4'd2, 4'd3, 16'd16, 16'd0},
    '{1'b0, 1'b1, 4'd2, 4'd3, 16'd0,  16'd4},
    '{1'b1, 1'b1, 4'd4, 4'd1, 16'd4,  16'd16},
    '{1'b0, 1'b1, 4'd0, 4'd0, 16'd0,  16'd0},
    '{1'b0, 1'b1, 4'd0, 4'd15, 16'd0, 16'd0},
    '{1'b1, 1'b1, 4'd3, 4'd5, 16'd8,  16'd1},
    '{1'b0, 1'b0, 4'd0, 4'd3, 16'd0,  16'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rtcEn = 0; pitEn = 0; flagClr = 0; divSel = 0; perSel = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state (R1, R5)
    doReset();
    #1;
    check("R5 reset wave", int'(pitWave), 0);
    check("R6 reset flag", int'(pitFlag), 0);
    check("R8 reset tick", int'(rtcTick), 0);

    // Vector table: ticks (R8, R2), wave rises (R4, R5), flag (R6)
    for (int v = 0; v < NV; v++) begin
      int nTicks;
      int nRises;
      logic prevWave;
      doReset();
      rtcEn = VEC[v].rtc; pitEn = VEC[v].pit;
      divSel = VEC[v].d; perSel = VEC[v].s;
      nTicks = 0; nRises = 0; prevWave = 1'b0;
      for (int j = 1; j <= RUN; j++) begin
        step();
        if (rtcTick) nTicks++;
        if (pitWave && !prevWave) nRises++;
        prevWave = pitWave;
      end
      check($sformatf("R8 vec%0d ticks", v), nTicks, int'(VEC[v].ticks));
      check($sformatf("R4 vec%0d rises", v), nRises, int'(VEC[v].rises));
      check($sformatf("R6 vec%0d flag", v), int'(pitFlag), (VEC[v].rises != 0) ? 1 : 0);
    end

    // R3 first edge after half period from stopped counter; R7 set beats clear
    doReset();
    pitEn = 1; perSel = 4'd3;
    repeat (7) step();
    check("R3 low before half period", int'(pitWave), 0);
    step();
    check("R3 high at half period", int'(pitWave), 1);
    flagClr = 1;
    step();
    flagClr = 0;
    check("R7 set wins over clear", int'(pitFlag), 1);
    step();
    check("R7 flag sticky", int'(pitFlag), 1);
    // R5 disable forces wave low, R1 counter cleared
    pitEn = 0;
    #1;
    check("R5 wave off when disabled", int'(pitWave), 0);
    step();
    flagClr = 1;
    step();
    flagClr = 0;
    check("R7 clear drops flag", int'(pitFlag), 0);
    step();
    check("R5 no flag while disabled", int'(pitFlag), 0);
    pitEn = 1;
    repeat (7) step();
    check("R1 restart from zero low", int'(pitWave), 0);
    step();
    check("R1 restart from zero high", int'(pitWave), 1);

    // R9 enable while RTC already running: no restart
    doReset();
    rtcEn = 1; divSel = 0;
    repeat (5) step();
    pitEn = 1; perSel = 4'd2;
    #1;
    check("R9 tapped bit visible at once", int'(pitWave), 1);
    @(negedge clk);
    repeat (3) step();
    check("R9 phase kept, bit2 of 8", int'(pitWave), 0);

    // R2 wrap at full width with d=15 and s=14
    doReset();
    rtcEn = 1; pitEn = 1; divSel = 4'd15; perSel = 4'd14;
    begin
      int nT;
      nT = 0;
      for (int j = 1; j <= 32767; j++) begin
        step();
        if (rtcTick) nT++;
      end
      check("R8 one tick per wrap", nT, 1);
      check("R8 tick at all ones", int'(rtcTick), 1);
      check("R4 wave high at top", int'(pitWave), 1);
      step();
      check("R2 wrap tick low", int'(rtcTick), 0);
      check("R2 wrap wave low", int'(pitWave), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule